// File: doc/BRIEF.md
# DMA Handshake Bus Port

This block lets an external DMA engine move data words between system memory and a small local FIFO buffer. It uses the same shared data bus, chip select and read/write strobes that ordinary register access uses. The block raises a request output while it has work and room to do it. The external side answers by driving an acknowledge input. On each bus cycle, the level of acknowledge decides the path. With acknowledge high, the cycle is a DMA data transfer. With it low, the cycle goes to programmed I/O: the block emits a one-cycle pulse for the register path and leaves the buffer alone.

A transfer is armed by a start pulse, which loads a word count and a direction. In direction 0 the system writes and the buffer fills, then local logic drains it. In direction 1 local logic fills the buffer and the system reads it. Every DMA strobe moves one word and lowers the remaining count by one. Strobes that find the buffer unable to serve raise a sticky overrun or underrun flag and move nothing. A done flag marks that the count has reached zero. Address-phase pins play no part: DMA cycles carry no address, and the buffer position comes from internal pointers.

Top module: `dma_bus_port`

## Requirements
- R1: `dreq` is high exactly when the remaining count is nonzero and the buffer can serve the armed direction. In direction 0 that means not full; in direction 1 it means not empty. After reset, `dreq` is 0, the count is 0, the direction is 0, and the buffer is empty.
- R2: A strobe is recognised at the first rising clock edge that samples `wr_n` or `rd_n` high after an edge that sampled it low. `cs_n` and `dack` are taken as sampled at that earlier edge. The write data on `ad_in` is taken at the recognising edge. Results are visible after the recognising edge.
- R3: A recognised strobe with `cs_n` low and `dack` low is a PIO cycle. It yields a one-cycle `pio_wr` or `pio_rd` pulse and changes neither the buffer, the count nor the flags.
- R4: In direction 0, a DMA write strobe with the buffer not full stores `ad_in` at the tail and lowers the count by one. Local pops then return the words in arrival order on `loc_rdata`.
- R5: In direction 1, `ad_oe` is high while `cs_n` and `rd_n` are low and `dack` is high. `ad_out` then shows the oldest buffered word, and the DMA read strobe's rising edge removes it and lowers the count by one.
- R6: `done` goes to 1 when a DMA transfer brings the count from 1 to 0. Strobes arriving while the count is 0 are ignored: no buffer change and no error flag.
- R7: A DMA write strobe while the buffer is full sets the sticky `err_ovr`. It stores nothing and leaves the count unchanged.
- R8: A DMA read strobe while the buffer is empty sets the sticky `err_und`. It removes nothing and leaves the count unchanged.
- R9: A strobe while `cs_n` was high is ignored by both paths.
- R10: A `start` pulse loads `len` and `dir_in`, and clears `done`, `err_ovr` and `err_und`. It keeps the buffer contents.
- R11: `loc_push` is accepted only in direction 1 with the buffer not full. `loc_pop` is accepted only in direction 0 with the buffer not empty. `loc_full` and `loc_empty` reflect the occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Arms a transfer |
| dir_in | input | 1 | Direction at start: 0 system writes, 1 system reads |
| len | input | CW | Word count loaded at start |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| dack | input | 1 | DMA acknowledge, high selects DMA path |
| ad_in | input | W | Data bus input |
| ad_out | output | W | Data bus output for DMA reads |
| ad_oe | output | 1 | Data bus output enable |
| dreq | output | 1 | DMA request |
| pio_wr | output | 1 | PIO write pulse |
| pio_rd | output | 1 | PIO read pulse |
| loc_push | input | 1 | Local write into buffer |
| loc_wdata | input | W | Local write data |
| loc_pop | input | 1 | Local read from buffer |
| loc_rdata | output | W | Oldest buffered word |
| loc_full | output | 1 | Buffer full |
| loc_empty | output | 1 | Buffer empty |
| done | output | 1 | Count reached zero |
| err_ovr | output | 1 | Sticky overrun flag |
| err_und | output | 1 | Sticky underrun flag |

## Verification
The bench builds the port with an 8-bit bus, a four-word buffer and a 6-bit count. With these values a handful of strobes fills the buffer before the count runs out. That brings the full-buffer request drop and the overrun path into reach, and a later pop shows that the rejected word never landed. Short counts of one and two words reach the count-to-zero edge, which sets done, and the ignored strobes after it. They also reach the underrun on an empty buffer, all within a few dozen cycles.

// File: rtl/dma_bus_port.sv
module dma_bus_port #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int CW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir_in,
  input  logic [CW-1:0] len,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          dack,
  input  logic [W-1:0]  ad_in,
  output logic [W-1:0]  ad_out,
  output logic          ad_oe,
  output logic          dreq,
  output logic          pio_wr,
  output logic          pio_rd,
  input  logic          loc_push,
  input  logic [W-1:0]  loc_wdata,
  input  logic          loc_pop,
  output logic [W-1:0]  loc_rdata,
  output logic          loc_full,
  output logic          loc_empty,
  output logic          done,
  output logic          err_ovr,
  output logic          err_und
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          cs_q, rd_q, wr_q, dack_q, dir_q;
  logic [CW-1:0] cnt;
  logic [AW-1:0] wp, rp;
  logic [OW-1:0] occ;
  logic [W-1:0]  mem [DEPTH];

  wire wr_rise = wr_n & ~wr_q;
  wire rd_rise = rd_n & ~rd_q;
  wire dma_cyc = ~cs_q & dack_q;
  wire pio_cyc = ~cs_q & ~dack_q;
  wire live    = cnt != '0;

  assign loc_full  = occ == OW'(DEPTH);
  assign loc_empty = occ == '0;

  wire dma_w    = wr_rise & dma_cyc & live & ~dir_q;
  wire dma_r    = rd_rise & dma_cyc & live & dir_q;
  wire push_dma = dma_w & ~loc_full;
  wire pop_dma  = dma_r & ~loc_empty;
  wire push     = push_dma | (loc_push & dir_q & ~loc_full);
  wire pop      = pop_dma | (loc_pop & ~dir_q & ~loc_empty);
  wire xfer     = push_dma | pop_dma;

  assign dreq      = live & (dir_q ? ~loc_empty : ~loc_full);
  assign pio_wr    = wr_rise & pio_cyc;
  assign pio_rd    = rd_rise & pio_cyc;
  assign ad_oe     = ~cs_n & ~rd_n & dack & dir_q;
  assign ad_out    = mem[rp];
  assign loc_rdata = mem[rp];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q <= 1'b1; rd_q <= 1'b1; wr_q <= 1'b1; dack_q <= 1'b0;
    end else begin
      cs_q <= cs_n; rd_q <= rd_n; wr_q <= wr_n; dack_q <= dack;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; dir_q <= 1'b0; done <= 1'b0; err_ovr <= 1'b0; err_und <= 1'b0;
    end else if (start) begin
      cnt <= len; dir_q <= dir_in; done <= 1'b0; err_ovr <= 1'b0; err_und <= 1'b0;
    end else begin
      if (xfer) cnt <= cnt - 1'b1;
      if (xfer && cnt == CW'(1)) done <= 1'b1;
      if (dma_w && loc_full) err_ovr <= 1'b1;
      if (dma_r && loc_empty) err_und <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; occ <= '0;
    end else begin
      if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      occ <= occ + OW'(push) - OW'(pop);
    end

  always_ff @(posedge clk)
    if (push) mem[wp] <= dir_q ? loc_wdata : ad_in;

  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !start) |=> cnt == $past(cnt) - 1'b1);
  p_pio_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pio_wr || pio_rd) && !start) |=> $stable(cnt) && $stable(err_ovr) && $stable(err_und));
  p_ovr_no_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_w && loc_full && !loc_pop) |=> $stable(occ) && err_ovr);
  p_done_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cnt == '0);
  p_occ_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OW'(DEPTH));
endmodule

// File: tb/test_dma_bus_port.sv
module test_dma_bus_port;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, dir_in = 1'b0;
  logic [5:0] len = '0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, dack = 1'b0;
  logic [7:0] ad_in = '0, ad_out, loc_wdata = '0, loc_rdata;
  logic ad_oe, dreq, pio_wr, pio_rd, loc_push = 1'b0, loc_pop = 1'b0;
  logic loc_full, loc_empty, done, err_ovr, err_und;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  dma_bus_port #(.W(8), .DEPTH(4), .CW(6)) i_dma_bus_port (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_in(dir_in), .len(len),
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .dack(dack), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .dreq(dreq), .pio_wr(pio_wr), .pio_rd(pio_rd),
    .loc_push(loc_push), .loc_wdata(loc_wdata), .loc_pop(loc_pop),
    .loc_rdata(loc_rdata), .loc_full(loc_full), .loc_empty(loc_empty),
    .done(done), .err_ovr(err_ovr), .err_und(err_und));

  localparam logic [9:0] VEC [4] = '{10'h286, 10'h2CA, 10'h30E, 10'h351};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic arm(logic d, logic [5:0] l);
    @(negedge clk); start = 1'b1; dir_in = d; len = l;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic cyc(logic csv, logic ack, logic is_rd, logic [7:0] d);
    @(negedge clk); cs_n = csv; dack = ack; ad_in = d;
    if (is_rd) rd_n = 1'b0; else wr_n = 1'b0;
    @(negedge clk); rd_n = 1'b1; wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1; dack = 1'b0;
  endtask

  task automatic dma_rd(logic [7:0] exp, logic chk_data);
    @(negedge clk); cs_n = 1'b0; dack = 1'b1; rd_n = 1'b0;
    #1 chk("R5 ad_oe", ad_oe, 1);
    if (chk_data) chk("R5 ad_out", ad_out, exp);
    @(negedge clk); rd_n = 1'b1;
    @(negedge clk); cs_n = 1'b1; dack = 1'b0;
  endtask

  task automatic lpush(logic [7:0] d);
    @(negedge clk); loc_push = 1'b1; loc_wdata = d;
    @(negedge clk); loc_push = 1'b0;
  endtask

  task automatic lpop(logic [7:0] exp, string req);
    @(negedge clk); chk(req, loc_rdata, exp); loc_pop = 1'b1;
    @(negedge clk); loc_pop = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #35 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset dreq", dreq, 0); chk("R1 reset empty", loc_empty, 1);
    chk("R6 reset done", done, 0); chk("R7 reset ovr", err_ovr, 0);

    arm(1'b0, 6'd4);
    chk("R1 dreq after start", dreq, 1);
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, 1'b1, 1'b0, VEC[i][9:2]);
      chk("R1 dreq table", dreq, VEC[i][1]);
      chk("R6 done table", done, VEC[i][0]);
    end
    chk("R11 full", loc_full, 1);
    for (int i = 0; i < 4; i++) lpop(VEC[i][9:2], "R4 order");
    chk("R11 empty", loc_empty, 1);

    arm(1'b0, 6'd6);
    cyc(1'b0, 1'b1, 1'b0, 8'h11); cyc(1'b0, 1'b1, 1'b0, 8'h22);
    cyc(1'b0, 1'b1, 1'b0, 8'h33); cyc(1'b0, 1'b1, 1'b0, 8'h44);
    chk("R1 dreq drops on full", dreq, 0);
    cyc(1'b0, 1'b1, 1'b0, 8'h55);
    chk("R7 ovr set", err_ovr, 1);
    lpop(8'h11, "R7 keep"); lpop(8'h22, "R7 keep");
    lpop(8'h33, "R7 keep"); lpop(8'h44, "R7 keep");
    chk("R7 nothing stored", loc_empty, 1);
    chk("R1 dreq back", dreq, 1);
    cyc(1'b0, 1'b1, 1'b0, 8'h66);
    chk("R7 count unchanged", done, 0);
    cyc(1'b0, 1'b1, 1'b0, 8'h77);
    chk("R6 done", done, 1);
    lpop(8'h66, "R4 order"); lpop(8'h77, "R4 order");

    arm(1'b1, 6'd2);
    chk("R10 clears ovr", err_ovr, 0); chk("R10 clears done", done, 0);
    chk("R1 dreq empty dir1", dreq, 0);
    lpush(8'hE0); lpush(8'hE1);
    chk("R11 local push", dreq, 1);
    dma_rd(8'hE0, 1'b1); dma_rd(8'hE1, 1'b1);
    chk("R6 done read", done, 1); chk("R1 dreq off", dreq, 0);
    chk("R5 popped", loc_empty, 1);

    arm(1'b1, 6'd1);
    dma_rd(8'h00, 1'b0);
    chk("R8 und set", err_und, 1); chk("R8 count kept", done, 0);
    lpush(8'hF5);
    dma_rd(8'hF5, 1'b1);
    chk("R8 then done", done, 1);

    arm(1'b0, 6'd1);
    @(negedge clk); cs_n = 1'b0; dack = 1'b0; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1; #1 chk("R3 pio_wr pulse", pio_wr, 1);
    @(negedge clk); chk("R3 pio_wr one cycle", pio_wr, 0);
    rd_n = 1'b0; #1 chk("R3 no ad_oe pio", ad_oe, 0);
    @(negedge clk); rd_n = 1'b1; #1 chk("R3 pio_rd pulse", pio_rd, 1);
    @(negedge clk); cs_n = 1'b1;
    chk("R3 buffer untouched", loc_empty, 1); chk("R3 count kept", done, 0);
    lpush(8'h99);
    chk("R11 push ignored dir0", loc_empty, 1);
    cyc(1'b1, 1'b1, 1'b0, 8'hAA);
    chk("R9 cs high ignored", loc_empty, 1); chk("R9 count kept", done, 0);
    cyc(1'b0, 1'b1, 1'b0, 8'h5A);
    chk("R2 write lands", done, 1);
    cyc(1'b0, 1'b1, 1'b0, 8'h6B);
    chk("R6 zero count no ovr", err_ovr, 0);
    lpop(8'h5A, "R2 sampled data");
    chk("R6 zero count no store", loc_empty, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule